// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a waveform timer whose period, output-pattern and compare registers each have a shadow buffer. Software writes over a simple single-cycle register bus. It can write an active register directly, which bypasses buffering, or it can write that register's buffer. A buffered value waits, with its own valid flag raised, until the counter reaches its hardware update point. The value is then moved into the active register and the flag drops.

A lock bit holds all pending buffers in place across update points. A force command moves every pending buffer at once, whether or not the lock is set. Any write is rejected, and raises an access-error pulse, if it targets a register whose buffer is pending while that register is still inside its fixed two-cycle synchronization window.

The counter runs up, down or up-down against TOP, which is the active period register. Each compare channel drives one PWM output.

Top module: `dbpwm_timer`

## Requirements
- R1: While and after reset: count is 0, all buffer-valid, sync-busy, lock and error outputs are 0, period is all ones, compare and pattern are 0.
- R2: A write to a buffer (address 3+2k; k=0 period, k=1 pattern, k=2+ch compare) stores the data and sets buffer-valid bit k. Any accepted write to a register or its buffer holds sync-busy bit k high for exactly 2 cycles.
- R3: At an update point, with lock clear, every register whose buffer is valid loads the buffer value and its valid bit clears. Update points are: count equal to TOP in up mode (mode 0), count 0 in down mode (mode 1), and count 0 while counting down in up-down mode (mode 2).
- R4: Writing address 0 with bit 1 set sets the lock. While the lock is set, update points copy nothing and the valid bits stay set.
- R5: Writing address 1 with bit 1 set clears the lock.
- R6: Writing address 0 with bits [7:5] equal to 3 copies every valid buffer into its active register and clears those valid bits, whatever the lock.
- R7: A write to register k (address 2+2k or 3+2k) while its buffer-valid and sync-busy bits are both 1 changes nothing. It raises the access-error output for exactly the next cycle.
- R8: A direct write to address 2+2k takes effect 2 cycles after the write and leaves the valid bits untouched.
- R9: In up mode, count resets to 0 on the cycle after it equals TOP and otherwise increments. If TOP is written directly below the current count, the counter runs through 255 and wraps to 0.
- R10: In down mode, count reloads with the TOP in effect on the cycle after it is 0 and otherwise decrements.
- R11: In up-down mode, count rises to TOP and then falls to 0, turning once at each end.
- R12: PWM output ch is high while count is below compare value ch. Pattern bit ch set overrides that output with pattern bit NUM_CH+ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Counting mode: 0 up, 1 down, 2 up-down |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Counter value |
| pwm_o | output | NUM_CH | PWM outputs |
| buf_valid_o | output | NUM_CH+2 | Buffer-valid flags, one per register |
| sync_busy_o | output | NUM_CH+2 | Sync-busy flags, one per register |
| lock_upd_o | output | 1 | Lock state |
| access_err_o | output | 1 | One-cycle rejected-write pulse |

## Verification
Period changes are tried in three ways, and each separates a different behaviour. A buffered write raised above the count shows that the change waits for the update point. A direct write dropped below the running count shows the wraparound that buffering avoids. Back-to-back writes inside the busy window show rejection apart from a normal buffer overwrite. Lock, unlock and force are applied with the same compare buffer pending, which tells the blocked copy, the released copy and the forced copy apart. All three counting modes run with buffered period changes so that each mode's own update point is exercised.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;

    typedef enum logic [1:0] {
        CNT_UP   = 2'd0,
        CNT_DOWN = 2'd1,
        CNT_DUAL = 2'd2
    } cnt_mode_e;

    localparam int ADDR_SET  = 0;
    localparam int ADDR_CLR  = 1;
    localparam int LOCK_BIT  = 1;
    localparam int CMD_LSB   = 5;
    localparam logic [2:0] CMD_FORCE = 3'd3;

    typedef struct packed {
        logic to_act;
        logic to_buf;
    } reg_hit_t;

    function automatic int act_addr(input int k);
        return 2 + 2 * k;
    endfunction

    function automatic int buf_addr(input int k);
        return 3 + 2 * k;
    endfunction

endpackage

// File: rtl/dbpwm_shadow_reg.sv
module dbpwm_shadow_reg #(
    parameter int W = 8,
    parameter int SYNC_DLY = 2,
    parameter logic [W-1:0] RST_VAL = '0,
    localparam int BC_W = $clog2(SYNC_DLY + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  dbpwm_pkg::reg_hit_t hit,
    input  logic [W-1:0]        wr_data,
    input  logic                upd_ok,
    output logic [W-1:0]        act_o,
    output logic                valid_o,
    output logic                busy_o,
    output logic                reject_o
);
    logic [W-1:0]    buf_q, stage_q;
    logic            stage_pend;
    logic [BC_W-1:0] bcnt;

    assign busy_o   = (bcnt != '0);
    assign reject_o = (hit.to_act || hit.to_buf) && valid_o && busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o      <= RST_VAL;
            buf_q      <= '0;
            stage_q    <= '0;
            stage_pend <= 1'b0;
            valid_o    <= 1'b0;
            bcnt       <= '0;
        end else begin
            // sync window countdown; a staged direct write lands at its end
            if (busy_o) begin
                bcnt <= bcnt - 1'b1;
                if (bcnt == BC_W'(1) && stage_pend) begin
                    act_o      <= stage_q;
                    stage_pend <= 1'b0;
                end
            end
            // buffer transfer overrides a landing direct write
            if (upd_ok && valid_o) begin
                act_o   <= buf_q;
                valid_o <= 1'b0;
            end
            if ((hit.to_act || hit.to_buf) && !reject_o) begin
                if (hit.to_buf) begin
                    buf_q   <= wr_data;
                    valid_o <= 1'b1;
                end else begin
                    stage_q    <= wr_data;
                    stage_pend <= 1'b1;
                end
                bcnt <= BC_W'(SYNC_DLY);
            end
        end
    end
endmodule

// File: rtl/dbpwm_counter.sv
module dbpwm_counter
    import dbpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt_o,
    output logic         upd_o
);
    logic going_up;

    always_comb begin
        unique case (mode)
            CNT_DOWN: upd_o = (cnt_o == '0);
            CNT_DUAL: upd_o = !going_up && (cnt_o == '0);
            default:  upd_o = (cnt_o == top);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o    <= '0;
            going_up <= 1'b1;
        end else begin
            unique case (mode)
                CNT_DOWN: cnt_o <= (cnt_o == '0) ? top : cnt_o - 1'b1;
                CNT_DUAL: begin
                    if (going_up) begin
                        if (cnt_o == top) begin
                            going_up <= 1'b0;
                            cnt_o    <= cnt_o - 1'b1;
                        end else begin
                            cnt_o <= cnt_o + 1'b1;
                        end
                    end else if (cnt_o == '0) begin
                        going_up <= 1'b1;
                        cnt_o    <= cnt_o + 1'b1;
                    end else begin
                        cnt_o <= cnt_o - 1'b1;
                    end
                end
                default: cnt_o <= (cnt_o == top) ? '0 : cnt_o + 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dbpwm_timer.sv
module dbpwm_timer
    import dbpwm_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int NUM_CH   = 2,
    parameter int SYNC_DLY = 2,
    parameter int ADDR_W   = 4,
    localparam int NREG    = NUM_CH + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [NREG-1:0]   buf_valid_o,
    output logic [NREG-1:0]   sync_busy_o,
    output logic              lock_upd_o,
    output logic              access_err_o
);
    localparam int IDX_PER  = 0;
    localparam int IDX_PATT = 1;
    localparam int IDX_CC0  = 2;

    logic [CNT_W-1:0] act_val [NREG];
    logic [NREG-1:0]  reject;
    logic             upd_evt, force_cmd, upd_ok, hit_set, hit_clr;

    assign hit_set   = wr_en_i && (int'(wr_addr_i) == ADDR_SET);
    assign hit_clr   = wr_en_i && (int'(wr_addr_i) == ADDR_CLR);
    assign force_cmd = hit_set && (wr_data_i[CMD_LSB +: 3] == CMD_FORCE);
    assign upd_ok    = (upd_evt && !lock_upd_o) || force_cmd;

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        reg_hit_t hit;
        assign hit.to_act = wr_en_i && (int'(wr_addr_i) == act_addr(k));
        assign hit.to_buf = wr_en_i && (int'(wr_addr_i) == buf_addr(k));
        dbpwm_shadow_reg #(
            .W       (CNT_W),
            .SYNC_DLY(SYNC_DLY),
            .RST_VAL ((k == IDX_PER) ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .hit     (hit),
            .wr_data (wr_data_i),
            .upd_ok  (upd_ok),
            .act_o   (act_val[k]),
            .valid_o (buf_valid_o[k]),
            .busy_o  (sync_busy_o[k]),
            .reject_o(reject[k])
        );
    end

    dbpwm_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .mode (cnt_mode_e'(mode_i)),
        .top  (act_val[IDX_PER]),
        .cnt_o(count_o),
        .upd_o(upd_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_upd_o   <= 1'b0;
            access_err_o <= 1'b0;
        end else begin
            access_err_o <= |reject;
            if (hit_set && wr_data_i[LOCK_BIT])      lock_upd_o <= 1'b1;
            else if (hit_clr && wr_data_i[LOCK_BIT]) lock_upd_o <= 1'b0;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pwm
        assign pwm_o[ch] = act_val[IDX_PATT][ch] ? act_val[IDX_PATT][NUM_CH + ch]
                                                 : (count_o < act_val[IDX_CC0 + ch]);
    end
endmodule

// File: rtl/dbpwm_timer_chk.sv
module dbpwm_timer_chk #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    localparam int NREG  = NUM_CH + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [CNT_W-1:0]  wr_data_i,
    input logic [CNT_W-1:0]  count_o,
    input logic [NREG-1:0]   buf_valid_o,
    input logic [NREG-1:0]   sync_busy_o,
    input logic              lock_upd_o,
    input logic              access_err_o
);
    logic force_wr, clr_wr;
    assign force_wr = wr_en_i && (wr_addr_i == '0) && (wr_data_i[7:5] == 3'd3);
    assign clr_wr   = wr_en_i && (int'(wr_addr_i) == 1) && wr_data_i[1];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_o == '0 && buf_valid_o == '0 && sync_busy_o == '0
                        && !lock_upd_o && !access_err_o));

    // R7
    err_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        access_err_o |-> $past(wr_en_i));

    // R6
    force_clears_chk: assert property (@(posedge clk) disable iff (rst)
        force_wr |=> (buf_valid_o == '0));

    // R5
    lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> !lock_upd_o);

    for (genvar k = 0; k < NREG; k++) begin : g_k
        // R4
        lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (lock_upd_o && buf_valid_o[k] && !force_wr) |=> buf_valid_o[k]);
        // R2
        busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(sync_busy_o[k]) |-> $past(wr_en_i));
    end
endmodule

bind dbpwm_timer dbpwm_timer_chk #(
    .CNT_W (CNT_W),
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .count_o     (count_o),
    .buf_valid_o (buf_valid_o),
    .sync_busy_o (sync_busy_o),
    .lock_upd_o  (lock_upd_o),
    .access_err_o(access_err_o)
);

// File: tb/dbpwm_timer_bench.sv
`timescale 1ns/1ps
module dbpwm_timer_bench;
    localparam int W = 8, NCH = 2, NR = NCH + 2;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0]    mode = 2'd0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  cnt;
    logic [NCH-1:0] pwm;
    logic [NR-1:0] bvalid, busy;
    logic          lock, err;

    dbpwm_timer u_dbpwm_timer (
        .clk(clk), .rst(rst), .mode_i(mode), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .count_o(cnt), .pwm_o(pwm), .buf_valid_o(bvalid),
        .sync_busy_o(busy), .lock_upd_o(lock), .access_err_o(err));

    int tests = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_act[NR], m_buf[NR], m_stage[NR], m_bc[NR];
    bit m_up, m_val[NR], m_sp[NR], m_lock, m_err;

    always @(posedge clk) begin
        int top, oc, ob[NR], k;
        bit upd, frc, ov[NR];
        if (rst) begin
            m_cnt = 0; m_up = 1; m_lock = 0; m_err = 0;
            for (int i = 0; i < NR; i++) begin
                m_act[i] = (i == 0) ? 255 : 0; m_buf[i] = 0; m_stage[i] = 0;
                m_bc[i] = 0; m_val[i] = 0; m_sp[i] = 0;
            end
        end else begin
            top = m_act[0]; oc = m_cnt;
            for (int i = 0; i < NR; i++) begin ob[i] = m_bc[i]; ov[i] = m_val[i]; end
            if (mode == 2'd1) begin
                upd = (oc == 0);
                m_cnt = (oc == 0) ? top : oc - 1;
            end else if (mode == 2'd2) begin
                upd = !m_up && oc == 0;
                if (m_up) begin
                    if (oc == top) begin m_up = 0; m_cnt = (oc + 255) % 256; end
                    else m_cnt = (oc + 1) % 256;
                end else if (oc == 0) begin m_up = 1; m_cnt = 1; end
                else m_cnt = oc - 1;
            end else begin
                upd = (oc == top);
                m_cnt = (oc == top) ? 0 : (oc + 1) % 256;
            end
            frc = wr_en && wr_addr == 0 && wr_data[7:5] == 3'd3;
            m_err = 0;
            for (int i = 0; i < NR; i++) begin
                if (ob[i] > 0) begin
                    m_bc[i] = ob[i] - 1;
                    if (ob[i] == 1 && m_sp[i]) begin m_act[i] = m_stage[i]; m_sp[i] = 0; end
                end
                if (ov[i] && ((upd && !m_lock) || frc)) begin m_act[i] = m_buf[i]; m_val[i] = 0; end
            end
            if (wr_en && wr_addr >= 2) begin
                k = (int'(wr_addr) - 2) / 2;
                if (k < NR) begin
                    if (ov[k] && ob[k] > 0) m_err = 1;
                    else begin
                        if (wr_addr[0]) begin m_buf[k] = wr_data; m_val[k] = 1; end
                        else begin m_stage[k] = wr_data; m_sp[k] = 1; end
                        m_bc[k] = 2;
                    end
                end
            end
            if (wr_en && wr_addr == 0 && wr_data[1]) m_lock = 1;
            else if (wr_en && wr_addr == 1 && wr_data[1]) m_lock = 0;
        end
    end

    task automatic chk(input string sig, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, sig, act, exp, $time);
        end
    endtask

    // compare against the reference every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("count", cnt, m_cnt);
            chk("lock", lock, m_lock);
            chk("access_err", err, m_err);
            for (int i = 0; i < NR; i++) begin
                chk("buf_valid", bvalid[i], m_val[i]);
                chk("sync_busy", busy[i], m_bc[i] > 0);
            end
            for (int c = 0; c < NCH; c++) begin
                int pe;
                pe = ((m_act[1] >> c) & 1) ? ((m_act[1] >> (NCH + c)) & 1)
                                           : (m_cnt < m_act[2 + c]);
                chk("pwm", pwm[c], pe);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        cur_req = "R1";
        chk("reset count", cnt, 0);
        chk("reset valid", bvalid, 0);
        rst = 1'b0;
        idle(4);
        cur_req = "R8";                 // direct writes land after the sync delay
        wr(2, 20); wr(6, 8); wr(8, 15);
        idle(50);
        cur_req = "R12";
        idle(25);
        cur_req = "R3";                 // buffered period grows at the update point
        wr(3, 30);
        idle(70);
        cur_req = "R7";                 // writes rejected inside busy window
        wr(3, 10); wr(2, 5); wr(3, 12);
        idle(6);
        cur_req = "R2";                 // overwrite once busy is over
        wr(3, 10);
        idle(60);
        cur_req = "R4";
        wr(0, 8'h02); wr(7, 3);
        idle(80);
        cur_req = "R5";
        wr(1, 8'h02);
        idle(30);
        cur_req = "R6";
        wr(0, 8'h02); wr(9, 25); idle(3);
        wr(0, 8'h62);
        idle(20); wr(1, 8'h02);
        cur_req = "R9";
        wr(3, 200);
        while (cnt != 8'd150) @(negedge clk);
        wr(2, 50);
        idle(400);
        cur_req = "R12";
        wr(4, 8'h05); idle(60);
        wr(5, 8'h0A); idle(80);
        wr(4, 8'h00); idle(10);
        cur_req = "R10";
        mode = 2'd1;
        idle(80); wr(3, 40); idle(150);
        cur_req = "R11";
        mode = 2'd2;
        idle(120); wr(3, 60); idle(300);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule